// File: doc/BRIEF.md
# Colour Lookup Table with Auto-Advancing Load Pointer

This block turns pixel words into 24-bit RGB for a raster video path. It holds a 256-entry colour table that a processor-style register port fills. The processor first writes a pointer-clear register and then streams colour words into a data register. Each data write lands at the current load position, and the position then steps forward, wrapping from 255 back to 0. A whole table loads with one clear followed by 256 data writes.

On the pixel side, a control register sets the colour depth to 1, 2, 4, 8, 16 or 32 bits per pixel. At depths up to 8 bits, the low pixel bits form one index that all three channels share. At 16 bits, each channel reads the table through its own overlapping byte window of the pixel. At 32 bits, each channel uses its own pixel byte. When the border input is high, a separate border colour register replaces the table output. The result is registered and appears one clock after the pixel.

Top module: `palette_lut`

## Requirements
- R1: After synchronous reset, `rgb_out` is 0, the border colour is 0, the depth is 8 bits per pixel (code 3) and the load position is entry 0.
- R2: A write to register address 0 (pointer clear) sets the load position to entry 0. The value on `wr_data` has no effect.
- R3: A write to register address 1 (colour data) stores `wr_data[23:0]` at the load position and then advances the position by one, modulo 256. The 257th data write after a clear overwrites entry 0.
- R4: A table entry and `rgb_out` use the same layout: red in bits [7:0], green in [15:8] and blue in [23:16].
- R5: A write to register address 3 (control) takes the depth code from `wr_data[7:5]`. The codes are 0=1, 1=2, 2=4, 3=8, 4=16 and 6=32 bits per pixel. A write carrying code 5 or 7 leaves the depth unchanged.
- R6: At 1, 2, 4 and 8 bits per pixel, the index is the low 1, 2, 4 or 8 bits of `pix_data`, zero-extended. All pixel bits above them are ignored, and all three channels use that one entry.
- R7: At 16 bits per pixel, red comes from the entry at `pix_data[7:0]`, green from the entry at `pix_data[11:4]` and blue from the entry at `pix_data[15:8]`.
- R8: At 32 bits per pixel, red comes from the entry at `pix_data[7:0]`, green from the entry at `pix_data[15:8]` and blue from the entry at `pix_data[23:16]`.
- R9: When `pix_border` is high, `rgb_out` takes the border colour at any depth. The border colour is loaded from `wr_data[23:0]` by a write to register address 2.
- R10: `rgb_out` responds to `pix_data` and `pix_border` at the first rising clock edge after they are presented, not before.
- R11: Writes to the border and control registers leave the load position unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 pointer clear, 1 colour data, 2 border, 3 control |
| wr_data | input | 32 | Register write value |
| pix_data | input | 32 | Pixel word at the selected depth |
| pix_border | input | 1 | High during the border region |
| rgb_out | output | 24 | Registered colour, blue[23:16] green[15:8] red[7:0] |

## Verification
Assertions check the load position on every cycle. After a pointer clear it reads 0, after a data write it has stepped by exactly one, and border or control writes leave it alone. They also check that the depth never holds an unused code, that an unused code cannot replace a legal one, that reset clears the output, and that border cycles deliver the border colour. The bench's scenarios are the only check on the table itself. They cover correct storage and wrap-around, the index each depth derives from the pixel, the overlapping 16-bit channel windows and the one-clock latency. For these, every result is compared with colours computed in the bench from a known fill pattern.

// File: rtl/vlut_pkg.sv
package vlut_pkg;

    localparam int CH_W      = 8;
    localparam int IDX_W     = 8;
    localparam int ENTRIES   = 1 << IDX_W;
    localparam int NUM_CH    = 3;
    localparam int RGB_W     = CH_W * NUM_CH;
    localparam int DEPTH_LSB = 5;
    localparam int DEPTH_W   = 3;

    typedef logic [CH_W-1:0]  chan_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        chan_t blu;
        chan_t grn;
        chan_t red;
    } rgb_t;

    typedef enum logic [DEPTH_W-1:0] {
        DEP_1  = 3'd0,
        DEP_2  = 3'd1,
        DEP_4  = 3'd2,
        DEP_8  = 3'd3,
        DEP_16 = 3'd4,
        DEP_32 = 3'd6
    } depth_e;

    typedef enum logic [1:0] {
        RA_CLEAR  = 2'd0,
        RA_DATA   = 2'd1,
        RA_BORDER = 2'd2,
        RA_CTRL   = 2'd3
    } reg_addr_e;

    function automatic logic depth_code_ok(logic [DEPTH_W-1:0] code);
        return (code != 3'd5) && (code != 3'd7);
    endfunction

    function automatic idx_t low_depth_mask(depth_e d);
        case (d)
            DEP_1:   return idx_t'(8'h01);
            DEP_2:   return idx_t'(8'h03);
            DEP_4:   return idx_t'(8'h0F);
            default: return idx_t'(8'hFF);
        endcase
    endfunction

endpackage

// File: rtl/vlut_regs.sv
module vlut_regs
    import vlut_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tab_we,
    output idx_t              tab_idx,
    output rgb_t              tab_val,
    output rgb_t              border,
    output depth_e            depth
);

    reg_addr_e             addr;
    idx_t                  ptr_q;
    logic [DEPTH_W-1:0]    new_code;

    assign addr     = reg_addr_e'(wr_addr);
    assign new_code = wr_data[DEPTH_LSB +: DEPTH_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            border <= '0;
            depth  <= DEP_8;
        end else if (wr_en) begin
            case (addr)
                RA_CLEAR:  ptr_q  <= '0;
                RA_DATA:   ptr_q  <= ptr_q + 1'b1;
                RA_BORDER: border <= rgb_t'(wr_data[RGB_W-1:0]);
                RA_CTRL: begin
                    if (depth_code_ok(new_code))
                        depth <= depth_e'(new_code);
                end
                default: ;
            endcase
        end
    end

    assign tab_we  = wr_en && (addr == RA_DATA);
    assign tab_idx = ptr_q;
    assign tab_val = rgb_t'(wr_data[RGB_W-1:0]);

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_CLEAR) |=> (ptr_q == '0));                       // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_DATA) |=> (ptr_q == idx_t'($past(ptr_q) + 1'b1))); // R3
    AST_PTR_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == RA_BORDER || addr == RA_CTRL)) |=> $stable(ptr_q)); // R11
    AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (rst)
        depth_code_ok(depth));                                                // R5
    AST_DEPTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_CTRL && !depth_code_ok(new_code)) |=> $stable(depth)); // R5

endmodule

// File: rtl/vlut_bank.sv
module vlut_bank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/vlut_index.sv
module vlut_index
    import vlut_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  depth_e     depth,
    input  logic [PIX_W-1:0] pix,
    output idx_t       r_idx,
    output idx_t       g_idx,
    output idx_t       b_idx
);

    idx_t shared_idx;

    assign shared_idx = pix[IDX_W-1:0] & low_depth_mask(depth);

    always_comb begin
        case (depth)
            DEP_16: begin
                r_idx = pix[7:0];
                g_idx = pix[11:4];
                b_idx = pix[15:8];
            end
            DEP_32: begin
                r_idx = pix[7:0];
                g_idx = pix[15:8];
                b_idx = pix[23:16];
            end
            default: begin
                r_idx = shared_idx;
                g_idx = shared_idx;
                b_idx = shared_idx;
            end
        endcase
    end

endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import vlut_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PIX_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              pix_border,
    output logic [RGB_W-1:0]  rgb_out
);

    logic   tab_we;
    idx_t   tab_idx;
    rgb_t   tab_val;
    rgb_t   border_rgb;
    depth_e depth;
    idx_t   r_idx, g_idx, b_idx;

    chan_t  wr_ch [NUM_CH];
    idx_t   rd_idx [NUM_CH];
    chan_t  rd_ch [NUM_CH];
    rgb_t   look_rgb;
    rgb_t   out_q;

    vlut_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tab_we  (tab_we),
        .tab_idx (tab_idx),
        .tab_val (tab_val),
        .border  (border_rgb),
        .depth   (depth)
    );

    vlut_index #(.PIX_W(PIX_W)) u_index (
        .depth (depth),
        .pix   (pix_data),
        .r_idx (r_idx),
        .g_idx (g_idx),
        .b_idx (b_idx)
    );

    assign wr_ch[0]  = tab_val.red;
    assign wr_ch[1]  = tab_val.grn;
    assign wr_ch[2]  = tab_val.blu;
    assign rd_idx[0] = r_idx;
    assign rd_idx[1] = g_idx;
    assign rd_idx[2] = b_idx;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
        vlut_bank #(.AW(IDX_W), .DW(CH_W)) u_bank (
            .clk   (clk),
            .we    (tab_we),
            .waddr (tab_idx),
            .wdata (wr_ch[c]),
            .raddr (rd_idx[c]),
            .rdata (rd_ch[c])
        );
    end

    assign look_rgb = '{blu: rd_ch[2], grn: rd_ch[1], red: rd_ch[0]};

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else if (pix_border)
            out_q <= border_rgb;
        else
            out_q <= look_rgb;
    end

    assign rgb_out = out_q;

    AST_RESET_BLACK: assert property (@(posedge clk)
        rst |=> (rgb_out == '0));                                              // R1
    AST_BORDER_PATH: assert property (@(posedge clk) disable iff (rst)
        pix_border |=> (rgb_out == $past(border_rgb)));                        // R9

endmodule

// File: tb/test_palette_lut.sv
`timescale 1ns/1ps
module test_palette_lut;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] pix_data = '0;
    logic        pix_border = 1'b0;
    logic [23:0] rgb_out;

    int vectors = 0;
    int misses  = 0;

    always #2.5 clk = ~clk;

    palette_lut i_palette_lut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pix_data   (pix_data),
        .pix_border (pix_border),
        .rgb_out    (rgb_out)
    );

    function automatic logic [7:0] fr(int i); return 8'(i); endfunction
    function automatic logic [7:0] fg(int i); return 8'(i) ^ 8'hFF; endfunction
    function automatic logic [7:0] fb(int i); return 8'(i * 5 + 7); endfunction
    function automatic logic [23:0] ent(int i); return {fb(i), fg(i), fr(i)}; endfunction

    task automatic chk(string req, logic [23:0] got, logic [23:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got %06h expected %06h", req, got, exp);
        end
    endtask

    task automatic reg_wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic apply(string req, logic [31:0] p, logic b, logic [23:0] exp);
        @(negedge clk);
        pix_data = p; pix_border = b;
        @(negedge clk);
        chk(req, rgb_out, exp);
    endtask

    task automatic set_depth(logic [2:0] code);
        reg_wr(2'd3, 32'hABCD_1F00 | (32'(code) << 5) | 32'h1F);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        logic [31:0] p;
        repeat (3) @(negedge clk);
        chk("R1 reset output", rgb_out, 24'h0);
        @(negedge clk);
        rst = 1'b0;

        // R1 border reset value
        apply("R1 border reset", 32'h0, 1'b1, 24'h0);

        // fill the table: clear, then 256 data writes (R3)
        reg_wr(2'd0, 32'h0);
        for (int i = 0; i < 256; i++) reg_wr(2'd1, {8'hEE, ent(i)});

        // default depth is 8 bpp (R1); low byte indexes all channels (R6, R4)
        for (int i = 0; i < 256; i++)
            apply("R6 R4 8bpp", {24'hC3A5E1 ^ 24'(i * 7), 8'(i)}, 1'b0, ent(i));

        // R3 wrap: 257th write lands on entry 0
        reg_wr(2'd1, 32'h0012_3456);
        apply("R3 wrap to 0", 32'h0, 1'b0, 24'h123456);
        apply("R3 entry 1 intact", 32'h1, 1'b0, ent(1));

        // R2: clear with nonzero data still goes to entry 0
        reg_wr(2'd0, 32'h0000_0077);
        reg_wr(2'd1, {8'h0, ent(0)});
        apply("R2 clear to entry 0", 32'h0, 1'b0, ent(0));
        apply("R2 entry 0x77 intact", 32'h77, 1'b0, ent(8'h77));

        // R11: border/control writes do not move pointer
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd1, 32'h00AA_BBCC);
        reg_wr(2'd2, 32'h0010_2030);
        set_depth(3'd3);
        reg_wr(2'd1, 32'h0011_2233);
        apply("R11 entry 0", 32'h0, 1'b0, 24'hAABBCC);
        apply("R11 entry 1", 32'h1, 1'b0, 24'h112233);
        apply("R11 entry 2 intact", 32'h2, 1'b0, ent(2));
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd1, {8'h0, ent(0)});
        reg_wr(2'd1, {8'h0, ent(1)});

        // R6 low depths 1, 2, 4 bpp
        for (int c = 0; c < 3; c++) begin
            set_depth(3'(c));
            for (int i = 0; i < 256; i++)
                apply("R6 low depth", {24'h5A5A5A, 8'(i)}, 1'b0,
                      ent(i & ((1 << (1 << c)) - 1)));
        end

        // R5: unused codes ignored (depth stays 1 bpp)
        set_depth(3'd0);
        set_depth(3'd5);
        apply("R5 code 5 ignored", 32'hFF, 1'b0, ent(1));
        set_depth(3'd7);
        apply("R5 code 7 ignored", 32'hFE, 1'b0, ent(0));

        // R7 16 bpp
        set_depth(3'd4);
        for (int k = 0; k < 4096; k++) begin
            p = {16'hBEEF, 16'(k * 37 + (k >> 3))};
            apply("R7 16bpp", p, 1'b0,
                  {fb(int'(p[15:8])), fg(int'(p[11:4])), fr(int'(p[7:0]))});
        end

        // R8 32 bpp
        set_depth(3'd6);
        lcg = 32'h1234_5678;
        for (int k = 0; k < 1024; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            apply("R8 32bpp", lcg, 1'b0,
                  {fb(int'(lcg[23:16])), fg(int'(lcg[15:8])), fr(int'(lcg[7:0]))});
        end

        // R9 border at several depths
        reg_wr(2'd2, 32'hFF9A_8B7C);
        apply("R9 border 32bpp", 32'h0102_0304, 1'b1, 24'h9A8B7C);
        set_depth(3'd4);
        apply("R9 border 16bpp", 32'h0000_1234, 1'b1, 24'h9A8B7C);
        set_depth(3'd1);
        apply("R9 border 2bpp", 32'h3, 1'b1, 24'h9A8B7C);
        apply("R9 border release", 32'h3, 1'b0, ent(3));

        // R10 latency: no change before the edge, change after it
        set_depth(3'd3);
        apply("R10 settle", 32'h10, 1'b0, ent(8'h10));
        @(negedge clk);
        pix_data = 32'h20;
        #1;
        chk("R10 before edge", rgb_out, ent(8'h10));
        @(negedge clk);
        chk("R10 after edge", rgb_out, ent(8'h20));
        pix_data = 32'h21;
        @(negedge clk);
        chk("R10 back to back", rgb_out, ent(8'h21));

        // R1 reset again clears output
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset output again", rgb_out, 24'h0);
        rst = 1'b0;
        apply("R1 depth back to 8bpp", 32'hFFFF_FF45, 1'b0, ent(8'h45));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule